// File: doc/BRIEF.md
# Fixed-Latency Result Writeback

This block models result writeback for a statically scheduled machine that has no scoreboard and no interlocks. Every issued operation arrives with a class, a destination register and a ready-made value. The block holds the value for the fixed number of delay slots that the class implies, then commits it to an internal register file. The read port always shows the committed contents. A consumer that reads a register inside a producer's delay window therefore gets the value from before that producer. Nothing is ever stalled, and no hazard is detected.

Operation classes are encoded on `iss_class` as 0 = single-cycle, 1 = multiply, 2 = load and 3 = branch. Single-cycle results have zero delay slots. Multiply results have one delay slot and load results have four. Each delayed class travels down its own shift line. As a result, at most one result per class reaches the register file on a given edge. A branch does not write the register file. A small branch controller counts five delay slots and then presents the redirect target for one cycle.

The branch controller has three states. BR_IDLE means no branch is in flight. BR_WAIT counts the delay slots. BR_FIRE is the single cycle in which the redirect is presented. The transitions are:

- IDLE_TO_WAIT: a branch is accepted while idle.
- WAIT_HOLD: the count is not yet zero.
- WAIT_TO_FIRE: the count reaches zero.
- FIRE_TO_IDLE: the redirect has been presented and no new branch is issued.
- FIRE_TO_WAIT: a new branch is issued in the fire cycle.

A branch issued while the controller is in BR_WAIT is flagged as an error and dropped.

Top module: `fixed_latency_wb`

## Requirements
- R1: After reset every register reads 0, `wb_en` is 0, `br_valid` is 0 and `br_err` is 0.
- R2: A single-cycle operation (class 0) captured on clock edge E is visible on the read port in the cycle after E.
- R3: A multiply (class 1) captured on edge E reads as the old value in the cycle after E. It commits on edge E+1.
- R4: A load (class 2) captured on edge E reads as the old value in the four cycles after E, E+1, E+2 and E+3. It commits on edge E+4.
- R5: When several results for the same register commit on the same edge, the one issued latest wins. The priority order is single-cycle, then multiply, then load.
- R6: A branch (class 3) accepted on edge E drives `br_valid` high with `br_target` equal to its value for exactly one cycle, the cycle after edge E+4. This leaves five delay slots.
- R7: A branch never changes the register named by its destination field.
- R8: A branch issued while another branch is still counting its delay slots raises `br_err` in that cycle. That branch produces no redirect.
- R9: A branch issued in the cycle where `br_valid` is high is accepted without error, and it gets its own redirect five delay slots later.
- R10: With `iss_valid` low, the class, destination and value inputs change no register and raise no `wb_en` bit.
- R11: During the cycle before a commit edge, `wb_en` shows one bit per committing lane: bit 0 single-cycle, bit 1 multiply, bit 2 load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation is issued this cycle |
| iss_class | input | 2 | 0 single-cycle, 1 multiply, 2 load, 3 branch |
| iss_dest | input | AW | Destination register index |
| iss_value | input | DW | Result value, or the target address for a branch |
| rd_addr | input | AW | Read port address |
| rd_data | output | DW | Committed contents of `rd_addr` |
| wb_en | output | 3 | Per-lane commit on the coming edge |
| wb_addr | output | 3*AW | Per-lane destination, lane 0 in the low bits |
| wb_data | output | 3*DW | Per-lane value, lane 0 in the low bits |
| br_valid | output | 1 | Redirect presented this cycle |
| br_target | output | DW | Redirect address |
| br_err | output | 1 | Branch issued while another branch is in flight |

## Verification
A wrong delay-line length or a wrong insertion point shows on the read port straight away. A result appears one cycle early, so a stale read returns the new value, or it appears a cycle late, so the first read after the window returns the old value. In either case the error is visible at most five cycles after issue. A wrong lane priority shows only when lanes collide on one register, so the bench builds collisions deliberately and reads the register in the cycle after the shared commit. A branch counter that is off by one, or a controller that sticks, moves or repeats the `br_valid` pulse. The scoreboard catches this at the first redirect.

// File: rtl/fixed_latency_wb_pkg.sv
package fixed_latency_wb_pkg;

    typedef enum logic [1:0] {
        OP_ALU    = 2'd0,
        OP_MUL    = 2'd1,
        OP_LOAD   = 2'd2,
        OP_BRANCH = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        BR_IDLE = 2'd0,
        BR_WAIT = 2'd1,
        BR_FIRE = 2'd2
    } br_state_e;

    localparam int unsigned NUM_LANES = 3;
    localparam int unsigned LANE_ALU  = 0;
    localparam int unsigned LANE_MUL  = 1;
    localparam int unsigned LANE_LOAD = 2;

endpackage

// File: rtl/wb_delay_line.sv
module wb_delay_line #(
    parameter int unsigned DW    = 32,
    parameter int unsigned AW    = 4,
    parameter int unsigned SLOTS = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_dest,
    input  logic [DW-1:0] in_value,
    output logic          out_valid,
    output logic [AW-1:0] out_dest,
    output logic [DW-1:0] out_value
);

    logic          stg_v [SLOTS];
    logic [AW-1:0] stg_d [SLOTS];
    logic [DW-1:0] stg_x [SLOTS];

    // The tail stage takes the new entry; every other stage takes its upper neighbour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                stg_v[i] <= 1'b0;
                stg_d[i] <= '0;
                stg_x[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS - 1; i++) begin
                stg_v[i] <= stg_v[i+1];
                stg_d[i] <= stg_d[i+1];
                stg_x[i] <= stg_x[i+1];
            end
            stg_v[SLOTS-1] <= in_valid;
            stg_d[SLOTS-1] <= in_dest;
            stg_x[SLOTS-1] <= in_value;
        end
    end

    assign out_valid = stg_v[0];
    assign out_dest  = stg_d[0];
    assign out_value = stg_x[0];

endmodule

// File: rtl/wb_regfile.sv
module wb_regfile #(
    parameter int unsigned DW    = 32,
    parameter int unsigned NREG  = 16,
    parameter int unsigned LANES = 3,
    localparam int unsigned AW   = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    wr_en,
    input  logic [LANES*AW-1:0] wr_addr,
    input  logic [LANES*DW-1:0] wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data
);

    logic [DW-1:0] mem [NREG];

    // Lanes are applied from the highest index down, so lane 0 takes effect last
    // and wins any same-register collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                mem[r] <= '0;
            end
        end else begin
            for (int l = LANES - 1; l >= 0; l--) begin
                if (wr_en[l]) begin
                    mem[wr_addr[l*AW +: AW]] <= wr_data[l*DW +: DW];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/wb_branch_fsm.sv
module wb_branch_fsm
    import fixed_latency_wb_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter int unsigned BR_SLOTS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [DW-1:0] req_target,
    output logic          redirect,
    output logic [DW-1:0] redirect_target,
    output logic          overlap_err
);

    localparam int unsigned CW = (BR_SLOTS > 2) ? $clog2(BR_SLOTS) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(BR_SLOTS - 2);

    br_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [DW-1:0] tgt_q, tgt_d;
    logic          accept;

    // A request is taken unless a branch is still counting its slots.
    assign accept = req && (state_q != BR_WAIT);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tgt_d   = tgt_q;
        unique case (state_q)
            BR_IDLE: begin
                if (accept) begin
                    state_d = BR_WAIT;
                    cnt_d   = CNT_LOAD;
                    tgt_d   = req_target;
                end
            end
            BR_WAIT: begin
                if (cnt_q == '0) begin
                    state_d = BR_FIRE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            BR_FIRE: begin
                if (accept) begin
                    state_d = BR_WAIT;
                    cnt_d   = CNT_LOAD;
                    tgt_d   = req_target;
                end else begin
                    state_d = BR_IDLE;
                end
            end
            default: begin
                state_d = BR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BR_IDLE;
            cnt_q   <= '0;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tgt_q   <= tgt_d;
        end
    end

    always_comb begin
        redirect        = 1'b0;
        redirect_target = tgt_q;
        overlap_err     = 1'b0;
        unique case (state_q)
            BR_IDLE: ;
            BR_WAIT: overlap_err = req;
            BR_FIRE: redirect = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fixed_latency_wb.sv
module fixed_latency_wb
    import fixed_latency_wb_pkg::*;
#(
    parameter int unsigned DW        = 32,
    parameter int unsigned NREG      = 16,
    parameter int unsigned MUL_SLOTS = 1,
    parameter int unsigned LD_SLOTS  = 4,
    parameter int unsigned BR_SLOTS  = 5,
    localparam int unsigned AW       = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_valid,
    input  logic [1:0]              iss_class,
    input  logic [AW-1:0]           iss_dest,
    input  logic [DW-1:0]           iss_value,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    output logic [NUM_LANES-1:0]    wb_en,
    output logic [NUM_LANES*AW-1:0] wb_addr,
    output logic [NUM_LANES*DW-1:0] wb_data,
    output logic                    br_valid,
    output logic [DW-1:0]           br_target,
    output logic                    br_err
);

    op_class_e             cls;
    logic [NUM_LANES-1:0]  lane_issue;
    logic                  br_req;

    assign cls    = op_class_e'(iss_class);
    assign br_req = iss_valid && (cls == OP_BRANCH);

    always_comb begin
        lane_issue            = '0;
        lane_issue[LANE_ALU]  = iss_valid && (cls == OP_ALU);
        lane_issue[LANE_MUL]  = iss_valid && (cls == OP_MUL);
        lane_issue[LANE_LOAD] = iss_valid && (cls == OP_LOAD);
    end

    // Lane 0 commits on the capture edge itself; later lanes pass through a delay line
    // whose length is the class's delay-slot count.
    genvar g;
    generate
        for (g = 0; g < NUM_LANES; g++) begin : g_lane
            if (g == LANE_ALU) begin : g_direct
                assign wb_en[g]             = lane_issue[g];
                assign wb_addr[g*AW +: AW]  = iss_dest;
                assign wb_data[g*DW +: DW]  = iss_value;
            end else begin : g_delayed
                localparam int unsigned SLOTS = (g == LANE_MUL) ? MUL_SLOTS : LD_SLOTS;
                wb_delay_line #(
                    .DW    (DW),
                    .AW    (AW),
                    .SLOTS (SLOTS)
                ) u_line (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .in_valid  (lane_issue[g]),
                    .in_dest   (iss_dest),
                    .in_value  (iss_value),
                    .out_valid (wb_en[g]),
                    .out_dest  (wb_addr[g*AW +: AW]),
                    .out_value (wb_data[g*DW +: DW])
                );
            end
        end
    endgenerate

    wb_regfile #(
        .DW    (DW),
        .NREG  (NREG),
        .LANES (NUM_LANES)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wb_en),
        .wr_addr (wb_addr),
        .wr_data (wb_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    wb_branch_fsm #(
        .DW       (DW),
        .BR_SLOTS (BR_SLOTS)
    ) u_br (
        .clk             (clk),
        .rst_n           (rst_n),
        .req             (br_req),
        .req_target      (iss_value),
        .redirect        (br_valid),
        .redirect_target (br_target),
        .overlap_err     (br_err)
    );

endmodule

// File: rtl/fixed_latency_wb_chk.sv
module fixed_latency_wb_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            iss_valid,
    input logic [1:0]      iss_class,
    input logic [AW-1:0]   iss_dest,
    input logic [DW-1:0]   iss_value,
    input logic [2:0]      wb_en,
    input logic [3*AW-1:0] wb_addr,
    input logic [3*DW-1:0] wb_data,
    input logic            br_valid,
    input logic [DW-1:0]   br_target,
    input logic            br_err
);

    // R3
    mul_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class == 2'd1) |=>
            (wb_en[1] && wb_addr[AW +: AW] == $past(iss_dest) && wb_data[DW +: DW] == $past(iss_value)));

    // R4
    load_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class == 2'd2) |-> ##4
            (wb_en[2] && wb_addr[2*AW +: AW] == $past(iss_dest, 4) && wb_data[2*DW +: DW] == $past(iss_value, 4)));

    // R6
    redirect_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class == 2'd3 && !br_err) |-> ##5
            (br_valid && br_target == $past(iss_value, 5)));

    // R6
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> !br_valid);

    // R8
    overlap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_err |-> !br_valid);

endmodule

bind fixed_latency_wb fixed_latency_wb_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_class (iss_class),
    .iss_dest  (iss_dest),
    .iss_value (iss_value),
    .wb_en     (wb_en),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .br_valid  (br_valid),
    .br_target (br_target),
    .br_err    (br_err)
);

// File: tb/fixed_latency_wb_tb.sv
module fixed_latency_wb_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          iss_valid;
    logic [1:0]    iss_class;
    logic [AW-1:0] iss_dest;
    logic [DW-1:0] iss_value;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic [2:0]    wb_en;
    logic [3*AW-1:0] wb_addr;
    logic [3*DW-1:0] wb_data;
    logic          br_valid;
    logic [DW-1:0] br_target;
    logic          br_err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int            at;
        logic [DW-1:0] tgt;
    } br_exp_t;
    br_exp_t br_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fixed_latency_wb u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
        .iss_dest(iss_dest), .iss_value(iss_value), .rd_addr(rd_addr), .rd_data(rd_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .br_valid(br_valid),
        .br_target(br_target), .br_err(br_err)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    // Starts at a falling edge, returns at the falling edge after the capture edge.
    task automatic issue(input logic [1:0] c, input logic [AW-1:0] d, input logic [DW-1:0] v);
        iss_valid = 1'b1; iss_class = c; iss_dest = d; iss_value = v;
        @(posedge clk);
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    // Driver side of the redirect scoreboard.
    task automatic branch(input logic [AW-1:0] d, input logic [DW-1:0] v);
        br_exp_t e;
        issue(2'd3, d, v);
        e.at = cyc + 4;
        e.tgt = v;
        br_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor side of the redirect scoreboard: R6, R8, R9.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            #2;
            if (br_valid === 1'b1) begin
                if (br_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R8: unexpected redirect actual %h expected none (cycle %0d)", br_target, cyc);
                end else begin
                    br_exp_t e;
                    e = br_q.pop_front();
                    chk("R6 redirect cycle", DW'(cyc), DW'(e.at));
                    chk("R6 redirect target", br_target, e.tgt);
                end
            end else if (br_q.size() > 0 && br_q[0].at <= cyc) begin
                br_exp_t e;
                e = br_q.pop_front();
                n_chk++; n_fail++;
                $display("FAIL R6: redirect missing actual none expected %h at cycle %0d", e.tgt, e.at);
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    initial begin
        rst_n = 1'b0; iss_valid = 1'b0; iss_class = '0; iss_dest = '0; iss_value = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 reg3", 4'd3, 32'h0);
        chk("R1 wb_en", 32'(wb_en), 32'h0);
        chk("R1 br_valid", 32'(br_valid), 32'h0);
        chk("R1 br_err", 32'(br_err), 32'h0);

        // R2 single-cycle visible next cycle
        issue(2'd0, 4'd1, 32'h11);
        rd_chk("R2 alu visible", 4'd1, 32'h11);

        // R3 multiply: stale one cycle, then new; R11 lane bit
        issue(2'd1, 4'd2, 32'h22);
        rd_chk("R3 mul stale", 4'd2, 32'h0);
        chk("R11 mul lane", 32'(wb_en), 32'h2);
        idle(1);
        rd_chk("R3 mul visible", 4'd2, 32'h22);

        // R4 load: stale four cycles
        issue(2'd2, 4'd3, 32'h33);
        for (int i = 0; i < 4; i++) begin
            rd_chk("R4 load stale", 4'd3, 32'h0);
            if (i < 3) idle(1);
        end
        chk("R11 load lane", 32'(wb_en), 32'h4);
        idle(1);
        rd_chk("R4 load visible", 4'd3, 32'h33);

        // R5 three-way collision on r5: single-cycle issued last wins
        issue(2'd2, 4'd5, 32'hA);
        idle(2);
        issue(2'd1, 4'd5, 32'hB);
        iss_valid = 1'b1; iss_class = 2'd0; iss_dest = 4'd5; iss_value = 32'hC;
        #1;
        chk("R11 three lanes", 32'(wb_en), 32'h7);
        @(posedge clk); @(negedge clk);
        iss_valid = 1'b0;
        rd_chk("R5 alu wins", 4'd5, 32'hC);

        // R5 two-way collision on r6: multiply beats load
        issue(2'd2, 4'd6, 32'hD);
        idle(2);
        issue(2'd1, 4'd6, 32'hE);
        rd_chk("R5 r6 stale", 4'd6, 32'h0);
        chk("R11 mul+load lanes", 32'(wb_en), 32'h6);
        idle(1);
        rd_chk("R5 mul wins", 4'd6, 32'hE);

        // R6 R7 R8: branch, overlap rejected
        branch(4'd1, 32'h100);
        idle(1);
        iss_valid = 1'b1; iss_class = 2'd3; iss_dest = 4'd1; iss_value = 32'h200;
        #1;
        chk("R8 overlap err", 32'(br_err), 32'h1);
        @(posedge clk); @(negedge clk);
        iss_valid = 1'b0;
        idle(8);
        chk("R8 queue drained", 32'(br_q.size()), 32'h0);
        rd_chk("R7 dest untouched", 4'd1, 32'h11);

        // R9 branch in the fire cycle is accepted
        branch(4'd2, 32'h300);
        idle(4);
        iss_valid = 1'b1; iss_class = 2'd3; iss_dest = 4'd2; iss_value = 32'h400;
        #1;
        chk("R9 no err in fire", 32'(br_err), 32'h0);
        chk("R9 fire seen", 32'(br_valid), 32'h1);
        @(posedge clk); @(negedge clk);
        iss_valid = 1'b0;
        begin
            br_exp_t e;
            e.at = cyc + 4;
            e.tgt = 32'h400;
            br_q.push_back(e);
        end
        idle(8);
        chk("R9 queue drained", 32'(br_q.size()), 32'h0);

        // R10 idle inputs ignored
        iss_valid = 1'b0; iss_class = 2'd0; iss_dest = 4'd1; iss_value = 32'hDEAD;
        #1;
        chk("R10 no lane", 32'(wb_en), 32'h0);
        @(posedge clk); @(negedge clk);
        rd_chk("R10 reg unchanged", 4'd1, 32'h11);

        done = 1'b1;
        report();
    end

endmodule